// File: doc/BRIEF.md
# Auto-Negotiation Parallel Detection Arbiter

This block chooses the link technology of a 10/100 Ethernet PHY. Two strap inputs, sampled while reset is held, set the ability word that the PHY offers. After reset, a restart request or the loss of an established link, the arbiter first silences all link activity for a break-link interval. It then waits for one of two outcomes. The first is a link partner that has completed the code-word exchange; this is abstracted here to a `partnerDone` level plus a four-bit ability field. The second is a plain link signal from one of the two receivers, taken through parallel detection. From either outcome it resolves an operating mode and reports the partner abilities and the expansion status bits.

A millisecond tick input advances three timers whose lengths are parameters: break-link, autoneg-wait and link-fail-inhibit. A bench can shorten them to a few ticks. A management enable level and a restart pulse control the arbiter. When the PHY came out of reset in forced-technology mode, negotiation starts only after the enable has been seen low and then high again.

Top module: `an_pd_arbiter`

## Requirements
- R1: `advWord` holds the ability word picked by the straps while `rstN` was low. With `strapAll`=1 it is 9'h1E1. Otherwise `strapSel` 00, 01, 10 and 11 give 9'h021, 9'h041, 9'h081 and 9'h101. Bits 5, 6, 7 and 8 mean 10 half, 10 full, 100 half and 100 full. The word does not change between resets.
- R2: When `partnerDone` is high during detection and `partnerAbil` shares at least one ability with `advWord[8:5]` (field bit i is word bit i+5), the highest shared ability wins. The order is 100 full, then 100 half, then 10 full, then 10 half. `linkMode` becomes 4, 3, 2 or 1 respectively, `lpAbil` copies `partnerAbil` and `lpAnAble` is 1. `anComplete` rises once the receiver for the resolved speed reports link.
- R3: Parallel detection accepts `link100` only when `advWord[7]` is set and `link10` only when `advWord[5]` is set. A link that is not accepted, or a partner with no shared ability, never raises `anComplete`, and `linkMode` stays 0.
- R4: An accepted parallel-detected link that stays the only valid link for WAIT_MS ticks completes in half duplex. `linkMode` becomes 3 and `lpAbil` 4'b0100 for 100, or `linkMode` 1 and `lpAbil` 4'b0001 for 10. `lpAnAble` stays 0.
- R5: When `link10` and `link100` are both high during detection, `multiLinkFault` is set and negotiation does not complete.
- R6: Each new negotiation cycle begins by holding `txQuiet` high for BREAK_MS ticks, and `anComplete` is low throughout.
- R7: A `restartReq` pulse while negotiating or linked sets `restartBit`. The arbiter then enters the break-link phase and clears `anComplete`, `linkMode`, `lpAbil`, `lpAnAble` and `multiLinkFault`, and `restartBit` clears itself once that phase has begun.
- R8: When the link of the resolved speed drops while complete, the next cycle clears `anComplete` and starts a new break-link phase.
- R9: If `strapForced` was high during reset, nothing starts (`txQuiet` and `anComplete` stay low) until `anEnable` has been low and then high.
- R10: With `anEnable` low the arbiter is idle: `txQuiet`, `anComplete` and `linkMode` are 0.
- R11: After a shared-ability partner result, if no link of the resolved speed appears within INHIBIT_MS ticks, the arbiter starts a new break-link phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while low |
| msTick | input | 1 | One-cycle pulse per millisecond |
| strapSel | input | 2 | Strap pair selecting a single advertised ability |
| strapAll | input | 1 | Strap option advertising all abilities |
| strapForced | input | 1 | PHY started in forced-technology mode |
| anEnable | input | 1 | Management negotiation enable level |
| restartReq | input | 1 | Management restart pulse |
| link10 | input | 1 | 10BASE-T receiver sees valid link pulses |
| link100 | input | 1 | 100BASE-X receiver sees valid idles |
| partnerDone | input | 1 | Code-word exchange with partner finished |
| partnerAbil | input | 4 | Partner abilities {100F,100H,10F,10H} |
| advWord | output | 9 | Advertised ability word |
| txQuiet | output | 1 | Transmit and link pulses halted (break-link) |
| anComplete | output | 1 | Negotiation complete |
| linkMode | output | 3 | 0 none, 1 10H, 2 10F, 3 100H, 4 100F |
| lpAbil | output | 4 | Partner ability bits {100F,100H,10F,10H} |
| lpAnAble | output | 1 | Partner negotiated (not parallel-detected) |
| multiLinkFault | output | 1 | More than one receiver reported link |
| restartBit | output | 1 | Self-clearing restart indication |

## Verification
The assertions assume that the straps are steady while reset is low and that `msTick` is a single-cycle pulse. They also assume the receivers report link only for the technology the bench means to present, so that losing the resolved link always counts as a real drop. The stimulus changes inputs only on falling clock edges and re-applies reset with new straps before each random scenario. Within a scenario it keeps `partnerDone`, `partnerAbil` and the link levels constant until the outcome has been sampled.

// File: rtl/an_pkg.sv
package an_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_DETECT,
    ST_WAIT,
    ST_INHIBIT,
    ST_LINKUP
  } anState_t;

  localparam logic [2:0] MODE_NONE = 3'd0;
  localparam logic [2:0] MODE_10H  = 3'd1;
  localparam logic [2:0] MODE_10F  = 3'd2;
  localparam logic [2:0] MODE_100H = 3'd3;
  localparam logic [2:0] MODE_100F = 3'd4;

  typedef struct packed {
    logic clrTimer;
    logic clrStatus;
    logic setMlf;
    logic takeFlp;
    logic takePd100;
    logic takePd10;
    logic setComplete;
  } anStrobe_t;

  function automatic logic [8:0] advFromStraps(input logic allAbil, input logic [1:0] sel);
    logic [8:0] w;
    if (allAbil) w = 9'h1E1;
    else begin
      case (sel)
        2'b00:   w = 9'h021;
        2'b01:   w = 9'h041;
        2'b10:   w = 9'h081;
        default: w = 9'h101;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/an_datapath.sv
module an_datapath
  import an_pkg::*;
#(
  parameter int BREAK_MS   = 1300,
  parameter int WAIT_MS    = 750,
  parameter int INHIBIT_MS = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  anStrobe_t  strobe,
  input  logic [3:0] advAbil,
  input  logic [3:0] partnerAbil,
  output logic       flpOk,
  output logic       modeIs100,
  output logic       breakDone,
  output logic       waitDone,
  output logic       inhibitDone,
  output logic [2:0] mode,
  output logic [3:0] lpAbil,
  output logic       lpAnAble,
  output logic       mlf,
  output logic       complete
);

  localparam int MAX_MS_A = (BREAK_MS > WAIT_MS) ? BREAK_MS : WAIT_MS;
  localparam int MAX_MS   = (MAX_MS_A > INHIBIT_MS) ? MAX_MS_A : INHIBIT_MS;
  localparam int CNT_W    = $clog2(MAX_MS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_MS);
  localparam logic [CNT_W-1:0] BRK_C   = CNT_W'(BREAK_MS);
  localparam logic [CNT_W-1:0] WAIT_C  = CNT_W'(WAIT_MS);
  localparam logic [CNT_W-1:0] INH_C   = CNT_W'(INHIBIT_MS);

  logic [CNT_W-1:0] msCount;
  logic [3:0]       common;
  logic [2:0]       flpMode;

  // shared millisecond timer, restarted by the control on each phase entry
  always_ff @(posedge clk) begin
    if (!rstN)                             msCount <= '0;
    else if (strobe.clrTimer)              msCount <= '0;
    else if (msTick && msCount != CNT_MAX) msCount <= msCount + 1'b1;
  end

  assign breakDone   = (msCount >= BRK_C);
  assign waitDone    = (msCount >= WAIT_C);
  assign inhibitDone = (msCount >= INH_C);

  // priority resolution of the shared abilities
  assign common = advAbil & partnerAbil;
  assign flpOk  = |common;

  always_comb begin
    if (common[3])      flpMode = MODE_100F;
    else if (common[2]) flpMode = MODE_100H;
    else if (common[1]) flpMode = MODE_10F;
    else if (common[0]) flpMode = MODE_10H;
    else                flpMode = MODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrStatus) begin
      mode     <= MODE_NONE;
      lpAbil   <= '0;
      lpAnAble <= 1'b0;
      mlf      <= 1'b0;
      complete <= 1'b0;
    end else begin
      if (strobe.takeFlp) begin
        mode     <= flpMode;
        lpAbil   <= partnerAbil;
        lpAnAble <= 1'b1;
      end else if (strobe.takePd100) begin
        mode   <= MODE_100H;
        lpAbil <= 4'b0100;
      end else if (strobe.takePd10) begin
        mode   <= MODE_10H;
        lpAbil <= 4'b0001;
      end
      if (strobe.setMlf)      mlf      <= 1'b1;
      if (strobe.setComplete) complete <= 1'b1;
    end
  end

  assign modeIs100 = (mode == MODE_100H) || (mode == MODE_100F);

endmodule

// File: rtl/an_ctrl.sv
module an_ctrl
  import an_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapForced,
  input  logic       anEnable,
  input  logic       restartReq,
  input  logic       link10,
  input  logic       link100,
  input  logic       partnerDone,
  input  logic [3:0] advAbil,
  input  logic       flpOk,
  input  logic       modeIs100,
  input  logic       breakDone,
  input  logic       waitDone,
  input  logic       inhibitDone,
  output anStrobe_t  strobe,
  output logic       txQuiet,
  output logic       restartBit
);

  anState_t state, stateNext;
  logic armed, enPrev, restartPend, pdSel100, pdSelNext;
  logic qual10, qual100, bothLinks, pdLinkUp, resolvedLinkUp;

  assign qual10         = link10 & advAbil[0];
  assign qual100        = link100 & advAbil[2];
  assign bothLinks      = link10 & link100;
  assign pdLinkUp       = pdSel100 ? link100 : link10;
  assign resolvedLinkUp = modeIs100 ? link100 : link10;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    pdSelNext = pdSel100;
    if (state != ST_IDLE && !anEnable) begin
      stateNext        = ST_IDLE;
      strobe.clrStatus = 1'b1;
    end else if (restartPend && state != ST_IDLE && state != ST_BREAK) begin
      stateNext        = ST_BREAK;
      strobe.clrTimer  = 1'b1;
      strobe.clrStatus = 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (anEnable && armed) begin
          stateNext        = ST_BREAK;
          strobe.clrTimer  = 1'b1;
          strobe.clrStatus = 1'b1;
        end
        ST_BREAK: if (breakDone) stateNext = ST_DETECT;
        ST_DETECT: begin
          if (partnerDone && flpOk) begin
            stateNext       = ST_INHIBIT;
            strobe.takeFlp  = 1'b1;
            strobe.clrTimer = 1'b1;
          end else if (bothLinks) begin
            strobe.setMlf = 1'b1;
          end else if (qual100 || qual10) begin
            stateNext       = ST_WAIT;
            strobe.clrTimer = 1'b1;
            pdSelNext       = qual100;
          end
        end
        ST_WAIT: begin
          if (bothLinks) begin
            stateNext     = ST_DETECT;
            strobe.setMlf = 1'b1;
          end else if (!pdLinkUp) begin
            stateNext = ST_DETECT;
          end else if (waitDone) begin
            stateNext          = ST_LINKUP;
            strobe.takePd100   = pdSel100;
            strobe.takePd10    = !pdSel100;
            strobe.setComplete = 1'b1;
          end
        end
        ST_INHIBIT: begin
          if (resolvedLinkUp) begin
            stateNext          = ST_LINKUP;
            strobe.setComplete = 1'b1;
          end else if (inhibitDone) begin
            stateNext        = ST_BREAK;
            strobe.clrTimer  = 1'b1;
            strobe.clrStatus = 1'b1;
          end
        end
        ST_LINKUP: if (!resolvedLinkUp) begin
          stateNext        = ST_BREAK;
          strobe.clrTimer  = 1'b1;
          strobe.clrStatus = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      armed       <= !strapForced;
      enPrev      <= 1'b1;
      restartPend <= 1'b0;
      pdSel100    <= 1'b0;
    end else begin
      state    <= stateNext;
      pdSel100 <= pdSelNext;
      enPrev   <= anEnable;
      if (anEnable && !enPrev) armed <= 1'b1;
      if (state == ST_IDLE || state == ST_BREAK) restartPend <= 1'b0;
      else if (restartReq)                       restartPend <= 1'b1;
    end
  end

  assign txQuiet    = (state == ST_BREAK);
  assign restartBit = restartPend;

endmodule

// File: rtl/an_pd_arbiter.sv
module an_pd_arbiter
  import an_pkg::*;
#(
  parameter int BREAK_MS   = 1300,
  parameter int WAIT_MS    = 750,
  parameter int INHIBIT_MS = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic [1:0] strapSel,
  input  logic       strapAll,
  input  logic       strapForced,
  input  logic       anEnable,
  input  logic       restartReq,
  input  logic       link10,
  input  logic       link100,
  input  logic       partnerDone,
  input  logic [3:0] partnerAbil,
  output logic [8:0] advWord,
  output logic       txQuiet,
  output logic       anComplete,
  output logic [2:0] linkMode,
  output logic [3:0] lpAbil,
  output logic       lpAnAble,
  output logic       multiLinkFault,
  output logic       restartBit
);

  anStrobe_t strobe;
  logic flpOk, modeIs100, breakDone, waitDone, inhibitDone;

  // straps are captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) advWord <= advFromStraps(strapAll, strapSel);
  end

  an_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .strapForced (strapForced),
    .anEnable    (anEnable),
    .restartReq  (restartReq),
    .link10      (link10),
    .link100     (link100),
    .partnerDone (partnerDone),
    .advAbil     (advWord[8:5]),
    .flpOk       (flpOk),
    .modeIs100   (modeIs100),
    .breakDone   (breakDone),
    .waitDone    (waitDone),
    .inhibitDone (inhibitDone),
    .strobe      (strobe),
    .txQuiet     (txQuiet),
    .restartBit  (restartBit)
  );

  an_datapath #(
    .BREAK_MS   (BREAK_MS),
    .WAIT_MS    (WAIT_MS),
    .INHIBIT_MS (INHIBIT_MS)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .msTick      (msTick),
    .strobe      (strobe),
    .advAbil     (advWord[8:5]),
    .partnerAbil (partnerAbil),
    .flpOk       (flpOk),
    .modeIs100   (modeIs100),
    .breakDone   (breakDone),
    .waitDone    (waitDone),
    .inhibitDone (inhibitDone),
    .mode        (linkMode),
    .lpAbil      (lpAbil),
    .lpAnAble    (lpAnAble),
    .mlf         (multiLinkFault),
    .complete    (anComplete)
  );

endmodule

// File: rtl/an_pd_checker.sv
module an_pd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       link100,
  input logic [8:0] advWord,
  input logic       txQuiet,
  input logic       anComplete,
  input logic [2:0] linkMode,
  input logic       lpAnAble,
  input logic       multiLinkFault
);

  AST_ADV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(advWord)); // R1

  AST_COMPLETE_HAS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    anComplete |-> (linkMode != 3'd0)); // R2

  AST_PD_ONLY_ADVERTISED: assert property (@(posedge clk) disable iff (!rstN)
    (anComplete && !lpAnAble) |->
      ((linkMode == 3'd3 && advWord[7]) || (linkMode == 3'd1 && advWord[5]))); // R3

  AST_MLF_NOT_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(multiLinkFault) |-> !anComplete); // R5

  AST_QUIET_NOT_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
    txQuiet |-> !anComplete); // R6

  AST_DROP_100_RELINKS: assert property (@(posedge clk) disable iff (!rstN)
    (anComplete && linkMode >= 3'd3 && !link100) |=> !anComplete); // R8

endmodule

bind an_pd_arbiter an_pd_checker i_checker (
  .clk            (clk),
  .rstN           (rstN),
  .link100        (link100),
  .advWord        (advWord),
  .txQuiet        (txQuiet),
  .anComplete     (anComplete),
  .linkMode       (linkMode),
  .lpAnAble       (lpAnAble),
  .multiLinkFault (multiLinkFault)
);

// File: tb/test_an_pd_arbiter.sv
module test_an_pd_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int TICKP = 4;
  localparam int BRK = 12;
  localparam int WT  = 6;
  localparam int INH = 8;
  localparam int WINDOW = (BRK + WT + INH + 6) * TICKP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic [1:0] strapSel = '0;
  logic strapAll = 1'b0, strapForced = 1'b0, anEnable = 1'b0, restartReq = 1'b0;
  logic link10 = 1'b0, link100 = 1'b0, partnerDone = 1'b0;
  logic [3:0] partnerAbil = '0;
  logic [8:0] advWord;
  logic txQuiet, anComplete, lpAnAble, multiLinkFault, restartBit;
  logic [2:0] linkMode;
  logic [3:0] lpAbil;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  int tickCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tickCnt <= (tickCnt == TICKP-1) ? 0 : tickCnt + 1;
    msTick  <= (tickCnt == TICKP-1);
  end

  an_pd_arbiter #(.BREAK_MS(BRK), .WAIT_MS(WT), .INHIBIT_MS(INH)) i_an_pd_arbiter (
    .clk(clk), .rstN(rstN), .msTick(msTick), .strapSel(strapSel), .strapAll(strapAll),
    .strapForced(strapForced), .anEnable(anEnable), .restartReq(restartReq),
    .link10(link10), .link100(link100), .partnerDone(partnerDone), .partnerAbil(partnerAbil),
    .advWord(advWord), .txQuiet(txQuiet), .anComplete(anComplete), .linkMode(linkMode),
    .lpAbil(lpAbil), .lpAnAble(lpAnAble), .multiLinkFault(multiLinkFault), .restartBit(restartBit)
  );

  function automatic logic [8:0] expAdv(input logic allAbil, input logic [1:0] sel);
    return 9'h001 | (allAbil ? 9'h1E0 : (9'h020 << sel));
  endfunction

  function automatic int expMode(input logic [3:0] adv, input logic [3:0] abil);
    for (int i = 3; i >= 0; i--) if (adv[i] && abil[i]) return i + 1;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] sel, input logic allAbil, input logic forced, input logic en);
    @(negedge clk);
    rstN = 1'b0; strapSel = sel; strapAll = allAbil; strapForced = forced; anEnable = en;
    restartReq = 1'b0; link10 = 1'b0; link100 = 1'b0; partnerDone = 1'b0; partnerAbil = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitComplete(input int limit, output int cycles);
    cycles = 0;
    while (cycles < limit && !anComplete) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int cyc;
    int quietLen;
    bit seen;
    void'($urandom(32'd4711));

    // reset state with negotiation disabled
    doReset(2'b00, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 idle txQuiet", txQuiet, 0);
    chk("R10 idle complete", anComplete, 0);
    chk("R10 idle mode", linkMode, 0);
    chk("R7 restartBit at reset", restartBit, 0);
    chk("R5 mlf at reset", multiLinkFault, 0);

    // every strap option
    for (int s = 0; s < 5; s++) begin
      doReset(s[1:0], s == 4, 1'b0, 1'b0);
      @(negedge clk);
      chk("R1 advertisement word", advWord, expAdv(s == 4, s[1:0]));
    end

    // break-link length after start
    doReset(2'b11, 1'b0, 1'b0, 1'b1);
    quietLen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txQuiet) quietLen++;
      else if (quietLen > 0) break;
    end
    chk("R6 break-link length in range",
        int'(quietLen >= (BRK-1)*TICKP && quietLen <= (BRK+1)*TICKP), 1);

    // restart and link loss on a 100 parallel-detected link
    doReset(2'b10, 1'b0, 1'b0, 1'b1);
    link100 = 1'b1;
    waitComplete(WINDOW, cyc);
    chk("R4 100 parallel link completes", anComplete, 1);
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    chk("R7 restartBit set", restartBit, 1);
    repeat (2) @(negedge clk);
    chk("R7 restartBit self-clears", restartBit, 0);
    chk("R7 break-link after restart", txQuiet, 1);
    chk("R7 complete cleared", anComplete, 0);
    chk("R7 mode cleared", linkMode, 0);
    waitComplete(WINDOW, cyc);
    chk("R4 relink after restart", anComplete, 1);
    link100 = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 link loss clears complete", anComplete, 0);
    chk("R8 link loss starts break-link", txQuiet, 1);

    // disable while linked
    link100 = 1'b1;
    waitComplete(WINDOW, cyc);
    anEnable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 disable clears complete", anComplete, 0);
    chk("R10 disable no quiet", txQuiet, 0);

    // forced start needs enable toggle
    doReset(2'b10, 1'b0, 1'b1, 1'b1);
    link100 = 1'b1;
    repeat (150) @(negedge clk);
    chk("R9 forced start stays idle", anComplete, 0);
    chk("R9 forced start no quiet", txQuiet, 0);
    anEnable = 1'b0;
    @(negedge clk);
    anEnable = 1'b1;
    waitComplete(WINDOW, cyc);
    chk("R9 enable toggle starts negotiation", anComplete, 1);

    // link-fail-inhibit expiry
    doReset(2'b11, 1'b1, 1'b0, 1'b1);
    partnerDone = 1'b1;
    partnerAbil = 4'b1000;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i > 2 && !txQuiet) break;
    end
    seen = 1'b0;
    for (int i = 0; i < (INH + 4) * TICKP; i++) begin
      @(negedge clk);
      if (txQuiet) seen = 1'b1;
    end
    chk("R11 inhibit expiry restarts", int'(seen), 1);
    chk("R11 no completion without link", anComplete, 0);

    // random scenarios
    for (int it = 0; it < 60; it++) begin
      logic [1:0] sel;
      logic allAbil;
      int kind;
      logic [8:0] adv;
      sel = 2'($urandom_range(3));
      allAbil = ($urandom_range(3) == 0);
      kind = $urandom_range(2);
      adv = expAdv(allAbil, sel);
      doReset(sel, allAbil, 1'b0, 1'b1);
      if (kind == 0) begin
        logic [3:0] abil;
        int em;
        abil = 4'($urandom_range(15, 1));
        em = expMode(adv[8:5], abil);
        partnerDone = 1'b1;
        partnerAbil = abil;
        if (em >= 3) link100 = 1'b1;
        else if (em != 0) link10 = 1'b1;
        waitComplete(WINDOW, cyc);
        chk("R2 partner completion", anComplete, int'(em != 0));
        chk("R2 partner mode", linkMode, em);
        chk("R2 partner abilities", lpAbil, (em != 0) ? int'(abil) : 0);
        chk("R2 partner negotiated flag", lpAnAble, int'(em != 0));
        chk("R3 shared ability needed", int'(em == 0 && anComplete), 0);
      end else if (kind == 1) begin
        logic use100;
        logic qual;
        use100 = $urandom_range(1);
        qual = use100 ? adv[7] : adv[5];
        if (use100) link100 = 1'b1; else link10 = 1'b1;
        waitComplete(WINDOW, cyc);
        chk("R3 parallel detect qualified", anComplete, int'(qual));
        chk("R4 parallel mode", linkMode, qual ? (use100 ? 3 : 1) : 0);
        chk("R4 parallel abilities", lpAbil, qual ? (use100 ? 4 : 1) : 0);
        chk("R4 partner not negotiating", lpAnAble, 0);
        if (qual)
          chk("R4 autoneg-wait timing",
              int'(cyc >= (BRK+WT-2)*TICKP && cyc <= (BRK+WT+2)*TICKP), 1);
      end else begin
        link10 = 1'b1;
        link100 = 1'b1;
        waitComplete(WINDOW, cyc);
        chk("R5 multiple link fault", multiLinkFault, 1);
        chk("R5 no completion", anComplete, 0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule